// File: doc/BRIEF.md
# Burst Address Generator for a Four-Beat Synchronous Memory Burst

This block produces the word address for a synchronous memory that transfers data in bursts of four beats. When the memory controller accepts an external address, it pulses `load_i`. The block then captures the whole address. The high-order bits stay fixed for the rest of the burst. The two low bits are the start offset, and the generated beat addresses are built from it.

Each cycle in which the active-low advance input is low moves the burst to its next beat. When advance is high, the current beat is held, which suspends the burst. The beat order comes from a mode input, which the block registers once per clock:

- **Interleaved order** (mode high): the start offset XOR a beat count.
- **Linear order** (mode low): the start offset plus the beat count, wrapping inside the four-word block.

The output is the registered high bits joined to the generated offset. It is valid one cycle after the edge that loads or advances.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_ni` is low, `addr_o` is all zeros. After reset the registered mode is linear (0).
- R2: A clock edge with `load_i` high captures all of `addr_i`. From the next cycle, `addr_o` equals that address, with beat count zero.
- R3: With the registered mode equal to 1 (interleaved), the low two bits of `addr_o` on beat k are the start offset XOR k. The starts 00, 01, 10 and 11 therefore give 00-01-10-11, 01-00-11-10, 10-11-00-01 and 11-10-01-00.
- R4: With the registered mode equal to 0 (linear), the low two bits on beat k are (start offset + k) mod 4. The four starts therefore give 00-01-10-11, 01-10-11-00, 10-11-00-01 and 11-00-01-10.
- R5: An edge with `load_i` low and `advance_ni` high leaves the beat count unchanged. If the mode is also unchanged, `addr_o` holds its value (suspend).
- R6: Without a load, the bits of `addr_o` above the low two never change. A wrap from offset 11 to 00 carries nothing into them.
- R7: Advances after the fourth beat continue around the same four-address cycle. The fifth beat equals the first.
- R8: When `load_i` is high and `advance_ni` is low at the same edge, the load wins. `addr_o` shows the new start address at beat zero.
- R9: `mode_i` is sampled at the clock edge. A change to it alters `addr_o` only from the cycle after that edge. The current beat is then re-mapped from the stored start offset and beat count under the new order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Accepted address strobe; captures `addr_i` |
| advance_ni | input | 1 | Active-low advance to the next beat |
| mode_i | input | 1 | Order select: 1 interleaved, 0 linear |
| addr_i | input | 19 | External word address |
| addr_o | output | 19 | Current burst word address |

## Verification
Two functions can fall in the same cycle: a load and an advance, and a mode change and a held or advancing beat.

The bench provokes the first by asserting `load_i` with `advance_ni` low in the middle of a burst. It expects the new start address at beat zero, not one beat on.

It provokes the second by flipping `mode_i` between edges during an interleaved burst. It checks that the sample taken before the edge still follows the old order. It then checks that the sample after the edge re-maps the same beat count under the linear order.

// File: rtl/bag_pkg.sv
package bag_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/bag_mode_reg.sv
module bag_mode_reg
  import bag_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   mode_i,
  output order_e order_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) order_o <= ORD_LINEAR;
    else         order_o <= order_e'(mode_i);
  end
endmodule

// File: rtl/bag_beat_ctr.sv
module bag_beat_ctr #(
  parameter int unsigned BURST_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               step_i,
  input  logic [BURST_W-1:0] start_i,
  output logic [BURST_W-1:0] start_o,
  output logic [BURST_W-1:0] count_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_o <= '0;
      count_o <= '0;
    end else if (load_i) begin
      start_o <= start_i;
      count_o <= '0;
    end else if (step_i) begin
      count_o <= count_o + 1'b1; // wraps naturally within the block
    end
  end
endmodule

// File: rtl/bag_hi_reg.sv
module bag_hi_reg #(
  parameter int unsigned HI_W = 17
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [HI_W-1:0] hi_i,
  output logic [HI_W-1:0] hi_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hi_o <= '0;
    else if (load_i) hi_o <= hi_i;
  end
endmodule

// File: rtl/bag_order_map.sv
module bag_order_map
  import bag_pkg::*;
#(
  parameter int unsigned BURST_W = 2
) (
  input  order_e             order_i,
  input  logic [BURST_W-1:0] start_i,
  input  logic [BURST_W-1:0] count_i,
  output logic [BURST_W-1:0] offset_o
);
  logic [BURST_W-1:0] ilv_off;
  logic [BURST_W-1:0] lin_off;

  assign ilv_off = start_i ^ count_i;
  assign lin_off = start_i + count_i; // modulo 2**BURST_W by width

  always_comb begin
    unique case (order_i)
      ORD_INTERLEAVE: offset_o = ilv_off;
      default:        offset_o = lin_off;
    endcase
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bag_pkg::*;
#(
  parameter int unsigned ADDR_W  = 19,
  parameter int unsigned BURST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              advance_ni,
  input  logic              mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned HI_W = ADDR_W - BURST_W;

  order_e             order_q;
  logic [BURST_W-1:0] start_q;
  logic [BURST_W-1:0] count_q;
  logic [BURST_W-1:0] offset;
  logic [HI_W-1:0]    hi_q;

  bag_mode_reg u_mode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode_i),
    .order_o (order_q)
  );

  bag_hi_reg #(.HI_W(HI_W)) u_hi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .hi_i   (addr_i[ADDR_W-1:BURST_W]),
    .hi_o   (hi_q)
  );

  bag_beat_ctr #(.BURST_W(BURST_W)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .step_i  (!advance_ni),
    .start_i (addr_i[BURST_W-1:0]),
    .start_o (start_q),
    .count_o (count_q)
  );

  bag_order_map #(.BURST_W(BURST_W)) u_map (
    .order_i  (order_q),
    .start_i  (start_q),
    .count_i  (count_q),
    .offset_o (offset)
  );

  assign addr_o = {hi_q, offset};
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int unsigned ADDR_W  = 19,
  parameter int unsigned BURST_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic              advance_ni,
  input logic              mode_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] addr_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) AST_RESET_ZERO: assert (addr_o == '0); // R1
  end

  AST_LOAD_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> addr_o == $past(addr_i)); // R2

  AST_HOLD_ON_SUSPEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !load_i && advance_ni && $stable(mode_i)) |=> $stable(addr_o)); // R5

  AST_HI_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> addr_o[ADDR_W-1:BURST_W] == $past(addr_o[ADDR_W-1:BURST_W])); // R6

  AST_ADVANCE_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !load_i && !advance_ni && $stable(mode_i))
      |=> addr_o[BURST_W-1:0] != $past(addr_o[BURST_W-1:0])); // R7

  AST_LOAD_BEATS_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !advance_ni) |=> addr_o == $past(addr_i)); // R8
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .load_i     (load_i),
  .advance_ni (advance_ni),
  .mode_i     (mode_i),
  .addr_i     (addr_i),
  .addr_o     (addr_o)
);

// File: tb/burst_addr_gen_tb_top.sv
`timescale 1ns/1ps
module burst_addr_gen_tb_top;
  localparam int AW = 19;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load = 1'b0;
  logic          adv_n = 1'b1;
  logic          mode = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [AW-1:0] q_exp[$];
  string         q_tag[$];

  // reference state
  logic [AW-3:0] m_hi = '0;
  logic [1:0]    m_start = '0;
  logic [1:0]    m_cnt = '0;
  logic          m_mode = 1'b0;

  always #2.5 clk = ~clk;

  burst_addr_gen dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .load_i     (load),
    .advance_ni (adv_n),
    .mode_i     (mode),
    .addr_i     (addr_in),
    .addr_o     (addr_out)
  );

  function automatic logic [AW-1:0] model_addr();
    logic [1:0] off;
    off = m_mode ? (m_start ^ m_cnt) : 2'((m_start + m_cnt) & 2'b11);
    return {m_hi, off};
  endfunction

  task automatic step(input logic ld, input logic an, input logic md,
                      input logic [AW-1:0] a, input string tag);
    load = ld; adv_n = an; mode = md; addr_in = a;
    @(posedge clk); #1;
    if (ld) begin
      m_hi = a[AW-1:2]; m_start = a[1:0]; m_cnt = 2'd0;
    end else if (!an) begin
      m_cnt = m_cnt + 2'd1;
    end
    m_mode = md;
    q_exp.push_back(model_addr());
    q_tag.push_back(tag);
  endtask

  // monitor: compares one expectation per cycle, away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (q_exp.size() > 0) begin
        logic [AW-1:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        checks++;
        if (addr_out !== e) begin
          errors++;
          $display("FAIL %s: addr_o=%h expected=%h", t, addr_out, e);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (addr_out !== '0) begin
      errors++;
      $display("FAIL R1: addr_o=%h expected=%h", addr_out, {AW{1'b0}});
    end
    @(posedge clk); #1;
    rst_n = 1'b1;

    step(1'b0, 1'b1, 1'b0, '0, "R5 idle after reset");

    // linear bursts from each start, plus wrap beats
    for (int s = 0; s < 4; s++) begin
      step(1'b1, 1'b1, 1'b0, {17'h1ABCD - 17'(s), 2'(s)}, "R2 load linear");
      for (int k = 0; k < 3; k++) step(1'b0, 1'b0, 1'b0, '0, "R4 linear beat");
      step(1'b0, 1'b0, 1'b0, '0, "R7 linear wrap");
      step(1'b0, 1'b0, 1'b0, '0, "R6 linear no carry");
    end

    // interleaved bursts from each start
    for (int s = 0; s < 4; s++) begin
      step(1'b1, 1'b1, 1'b1, {17'h0F0F0 + 17'(s), 2'(s)}, "R2 load interleaved");
      for (int k = 0; k < 3; k++) step(1'b0, 1'b0, 1'b1, '0, "R3 interleaved beat");
      step(1'b0, 1'b0, 1'b1, '0, "R7 interleaved wrap");
    end

    // suspend in the middle of a burst
    step(1'b1, 1'b1, 1'b1, {17'h12345, 2'b10}, "R2 load before suspend");
    step(1'b0, 1'b0, 1'b1, '0, "R3 beat before suspend");
    step(1'b0, 1'b1, 1'b1, '0, "R5 suspend hold");
    step(1'b0, 1'b1, 1'b1, '0, "R5 suspend hold again");
    step(1'b0, 1'b0, 1'b1, '0, "R3 resume after suspend");

    // load and advance in the same cycle
    step(1'b1, 1'b0, 1'b1, {17'h00077, 2'b11}, "R8 load beats advance");
    step(1'b0, 1'b0, 1'b1, '0, "R8 first beat after load");

    // mode change mid-burst: previous sample still old order, next re-mapped
    step(1'b1, 1'b1, 1'b1, {17'h1FFFF, 2'b01}, "R2 load before mode change");
    step(1'b0, 1'b0, 1'b1, '0, "R3 beat before mode change");
    step(1'b0, 1'b1, 1'b0, '0, "R9 mode change takes effect after edge");
    step(1'b0, 1'b0, 1'b0, '0, "R9 linear continues");
    step(1'b0, 1'b1, 1'b1, '0, "R9 back to interleaved");

    load = 1'b0; adv_n = 1'b1;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule